// File: doc/BRIEF.md
# Masked Global Interrupt Aggregator

This block gathers every interrupt-capable source of a dual-UART host bridge into one 32-bit status and control word and drives a single active-high interrupt line toward the host. The sources are two UART channel requests, eleven general-purpose pins (each with its own polarity setting), a parallel-port request and a power-down request pulse. Software reads the word to find which source is pending. Software writes the word to choose which sources may raise the host interrupt.

Two mode inputs change what some bits mean. The device-mode input decides whether status bit 4 and mask bit 20 refer to general-purpose pin 0 or to the parallel port. A 2-bit local-control field decides whether status bit 5 and mask bit 21 refer to pin 1 or to a power-down request. In the power-down case, bit 5 is a sticky flag that the power-down pulse sets and that a register read clears.

Top module: `gint_aggregator`

## Requirements
- R1: Status bits [1:0] show the live level of `uart_irq[1:0]` (bit 0 for channel 0, bit 1 for channel 1) in the same cycle.
- R2: Each conditioned pin value is `mio_pin[i] XOR mio_invert[i]`. Status bits [14:6] show the conditioned values of pins 2 to 10, with pin 2 at bit 6.
- R3: Status bit 4 shows the conditioned value of pin 0 when `dev_mode` is 0, and `par_irq` when `dev_mode` is 1.
- R4: When `lctl_mode` is 2'b00, status bit 5 shows the conditioned value of pin 1.
- R5: When `lctl_mode` is not 2'b00, status bit 5 shows a sticky flag. A clock edge with `pdn_pulse` high sets the flag. A clock edge with `rd_stb` high and `pdn_pulse` low clears it. If both are high at the same edge, the flag is set. While `lctl_mode` is 2'b00 the flag is held clear.
- R6: A clock edge with `wr_en` high loads `wr_data[17:16]`, `wr_data[20]` and `wr_data[21]` into the mask bits, which read back at those same positions. All other read bits are always 0, whatever was written: [3:2], 15, [19:18] and [31:22].
- R7: After reset, all mask bits are 0, the sticky flag is 0 and `host_irq` is 0.
- R8: `host_irq` is combinational from the current state. It equals the OR of: UART channel k AND mask bit 16+k; the bit-4 source AND mask bit 20; the bit-5 value AND mask bit 21. Pins 2 to 10 never affect `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_irq | input | 2 | UART channel interrupt requests, bit k for channel k |
| mio_pin | input | 11 | Raw general-purpose pin levels |
| mio_invert | input | 11 | Per-pin polarity; 1 inverts the pin |
| par_irq | input | 1 | Parallel-port interrupt request |
| pdn_pulse | input | 1 | Power-down request pulse |
| dev_mode | input | 1 | 0: bit 4 and mask 20 use pin 0; 1: they use the parallel port |
| lctl_mode | input | 2 | 00: bit 5 and mask 21 use pin 1; otherwise they use the power-down flag |
| rd_stb | input | 1 | Register read strobe; clears the sticky flag |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Status and mask word |
| host_irq | output | 1 | Active-high host interrupt |

## Verification
The assertions assume that the mode inputs and write data are stable across each sampling edge and are never unknown after reset. They also assume that `pdn_pulse` and `rd_stb` are single-cycle-qualified levels that the block samples once per edge. The bench drives every input on the falling edge, so each rising edge sees settled values. It changes the mode selects only occasionally, so that mode transitions occur mixed in with sticky-flag activity. It also forces coincident set and clear cycles so that the set-wins rule is exercised.

// File: rtl/gint_pkg.sv
package gint_pkg;
    localparam int NUM_UART  = 2;
    localparam int NUM_MIO   = 11;
    localparam int WORD_W    = 32;
    localparam int LCTL_W    = 2;

    // status positions
    localparam int ST_UART_LO = 0;
    localparam int ST_ALT0    = 4;
    localparam int ST_ALT1    = 5;
    localparam int ST_MIO_LO  = 6;
    localparam int MIO_HI_CNT = NUM_MIO - 2;

    // mask positions
    localparam int MK_UART_LO = 16;
    localparam int MK_ALT0    = 20;
    localparam int MK_ALT1    = 21;

    typedef struct packed {
        logic [NUM_UART-1:0] uart;
        logic                alt0;
        logic                alt1;
    } mask_t;
endpackage

// File: rtl/gint_mio_cond.sv
module gint_mio_cond #(
    parameter int W = 11
) (
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] inv_i,
    output logic [W-1:0] cond_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign cond_o[g] = pin_i[g] ^ inv_i[g];
    end
endmodule

// File: rtl/gint_sticky.sv
module gint_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (!enable_i)      flag_d = 1'b0;
        else if (set_i)     flag_d = 1'b1;
        else if (clr_i)     flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && set_i) |=> flag_q);
    // R5
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && clr_i && !set_i) |=> !flag_q);
    // R5
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !flag_q);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/gint_mask_reg.sv
module gint_mask_reg
    import gint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output mask_t             mask_o
);
    mask_t mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en_i) begin
            mask_d.uart = wr_data_i[MK_UART_LO +: NUM_UART];
            mask_d.alt0 = wr_data_i[MK_ALT0];
            mask_d.alt1 = wr_data_i[MK_ALT1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_q));
    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mask_q.alt1 == $past(wr_data_i[MK_ALT1])) &&
                    (mask_q.uart == $past(wr_data_i[MK_UART_LO +: NUM_UART])));
endmodule

// File: rtl/gint_aggregator.sv
module gint_aggregator
    import gint_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_UART-1:0] uart_irq,
    input  logic [NUM_MIO-1:0]  mio_pin,
    input  logic [NUM_MIO-1:0]  mio_invert,
    input  logic                par_irq,
    input  logic                pdn_pulse,
    input  logic                dev_mode,
    input  logic [LCTL_W-1:0]   lctl_mode,
    input  logic                rd_stb,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    output logic                host_irq
);
    logic [NUM_MIO-1:0] mio_int;
    logic               pdn_active;
    logic               pdn_flag;
    logic               alt0_src;
    logic               alt1_src;
    mask_t              mask;

    gint_mio_cond #(.W(NUM_MIO)) u_cond (
        .pin_i  (mio_pin),
        .inv_i  (mio_invert),
        .cond_o (mio_int)
    );

    assign pdn_active = (lctl_mode != '0);

    gint_sticky u_pdn (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (pdn_active),
        .set_i    (pdn_pulse),
        .clr_i    (rd_stb),
        .flag_o   (pdn_flag)
    );

    gint_mask_reg u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .mask_o    (mask)
    );

    always_comb begin
        alt0_src = dev_mode   ? par_irq  : mio_int[0];
        alt1_src = pdn_active ? pdn_flag : mio_int[1];
    end

    always_comb begin
        rd_data = '0;
        rd_data[ST_UART_LO +: NUM_UART]  = uart_irq;
        rd_data[ST_ALT0]                 = alt0_src;
        rd_data[ST_ALT1]                 = alt1_src;
        rd_data[ST_MIO_LO +: MIO_HI_CNT] = mio_int[NUM_MIO-1:2];
        rd_data[MK_UART_LO +: NUM_UART]  = mask.uart;
        rd_data[MK_ALT0]                 = mask.alt0;
        rd_data[MK_ALT1]                 = mask.alt1;
    end

    always_comb begin
        host_irq = (|(uart_irq & mask.uart))
                 | (alt0_src & mask.alt0)
                 | (alt1_src & mask.alt1);
    end

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[MK_ALT1:MK_UART_LO] == '0) |-> !host_irq);
    // R8
    uart_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rd_data[MK_UART_LO +: NUM_UART] & uart_irq)) |-> host_irq);
    // R7
    reset_mask_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data[MK_ALT1:MK_UART_LO] == '0));
endmodule

// File: tb/sim_gint_aggregator.sv
module sim_gint_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  uart_irq = '0;
    logic [10:0] mio_pin = '0;
    logic [10:0] mio_invert = '0;
    logic        par_irq = 1'b0;
    logic        pdn_pulse = 1'b0;
    logic        dev_mode = 1'b0;
    logic [1:0]  lctl_mode = '0;
    logic        rd_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        host_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    bit m_mu0, m_mu1, m_m20, m_m21, m_flag;

    gint_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .uart_irq(uart_irq), .mio_pin(mio_pin),
        .mio_invert(mio_invert), .par_irq(par_irq), .pdn_pulse(pdn_pulse),
        .dev_mode(dev_mode), .lctl_mode(lctl_mode), .rd_stb(rd_stb),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .host_irq(host_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit [31:0] e;
        bit src4, src5;
        e = 0;
        e[0] = uart_irq[0];
        e[1] = uart_irq[1];
        for (int p = 2; p <= 10; p++) e[p + 4] = mio_pin[p] ^ mio_invert[p];
        src4 = dev_mode ? par_irq : (mio_pin[0] ^ mio_invert[0]);
        src5 = (lctl_mode == 2'b00) ? (mio_pin[1] ^ mio_invert[1]) : m_flag;
        e[4] = src4;
        e[5] = src5;
        e[16] = m_mu0; e[17] = m_mu1; e[20] = m_m20; e[21] = m_m21;
        check("R1 uart status", {30'd0, rd_data[1:0]}, {30'd0, e[1:0]});
        check("R2 mio status", {23'd0, rd_data[14:6]}, {23'd0, e[14:6]});
        check("R3 bit4 select", {31'd0, rd_data[4]}, {31'd0, e[4]});
        if (lctl_mode == 2'b00)
            check("R4 bit5 pin1", {31'd0, rd_data[5]}, {31'd0, e[5]});
        else
            check("R5 bit5 sticky", {31'd0, rd_data[5]}, {31'd0, e[5]});
        check("R6 masks and reserved zero", rd_data & 32'hFFFF_800C | rd_data & 32'h0033_0000,
              e & 32'h0033_0000);
        check("R8 host_irq", {31'd0, host_irq},
              {31'd0, (uart_irq[0] & m_mu0) | (uart_irq[1] & m_mu1) | (src4 & m_m20) | (src5 & m_m21)});
    endtask

    task automatic model_edge();
        if (lctl_mode == 2'b00)  m_flag = 0;
        else if (pdn_pulse)      m_flag = 1;
        else if (rd_stb)         m_flag = 0;
        if (wr_en) begin
            m_mu0 = wr_data[16]; m_mu1 = wr_data[17];
            m_m20 = wr_data[20]; m_m21 = wr_data[21];
        end
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        // reset with activity on inputs that must not leak through
        lctl_mode = 2'b01; pdn_pulse = 1'b1; wr_en = 1'b1; wr_data = '1;
        uart_irq = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pdn_pulse = 1'b0; wr_en = 1'b0;
        #1;
        // R7 reset state
        check("R7 masks after reset", rd_data & 32'h0033_0000, 32'h0);
        check("R7 flag after reset", {31'd0, rd_data[5]}, 32'h0);
        check("R7 host_irq after reset", {31'd0, host_irq}, 32'h0);
        m_mu0 = 0; m_mu1 = 0; m_m20 = 0; m_m21 = 0; m_flag = 0;

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            uart_irq  = 2'($urandom);
            mio_pin   = 11'($urandom);
            if ($urandom_range(0, 15) == 0) mio_invert = 11'($urandom);
            par_irq   = 1'($urandom);
            pdn_pulse = ($urandom_range(0, 5) == 0);
            rd_stb    = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 40) == 0) dev_mode = ~dev_mode;
            if ($urandom_range(0, 60) == 0) lctl_mode = 2'($urandom);
            wr_en   = ($urandom_range(0, 7) == 0);
            wr_data = $urandom;
            if (i % 50 == 7) begin           // R5 set and clear at the same edge
                lctl_mode = 2'b10; pdn_pulse = 1'b1; rd_stb = 1'b1;
            end
            if (i % 50 == 8) begin           // R5 clear-on-read alone
                pdn_pulse = 1'b0; rd_stb = 1'b1;
            end
            if (i % 97 == 3) begin           // R6 all-ones write, reserved stays zero
                wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
            end
            #1;
            compare_all();
            @(posedge clk);
            model_edge();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule